// File: doc/BRIEF.md
# Serial Wiper Register Interface

This block is the serial front end of a bank of four 8-bit wiper settings. A host frames each transfer with a select line. While select is high, the block waits for a start bit on the serial input. It then takes two address bits and eight data bits, each on a rising clock edge. While the new data bits come in, the old contents of the addressed register go out on the serial output, least significant bit first. Every write is therefore also a read, and the read empties the register. One clock after the last data bit, the new value reaches the addressed wiper output.

If the host drops select after the address has been taken but before the new value is committed, the addressed register is reloaded from its nonvolatile copy. The nonvolatile copies come in on an input port. When the stored copy matches the active setting, a host can poll a setting without disturbing it. The serial output has an enable that follows select, so several devices can share one return line.

The frame controller has four states:
- **IDLE**: waits for a start bit.
- **ADDR**: collects the address bits.
- **DATA**: shifts data in and old data out.
- **COMMIT**: writes the new value.

The transitions are:
- IDLE→ADDR on a high input bit.
- ADDR→DATA after the last address bit.
- DATA→COMMIT after the eighth data bit.
- COMMIT→IDLE always.
- Any state→IDLE whenever select is low at a clock edge. From DATA or COMMIT this transition also restores the register.

Top module: `sw_wiper_if`

## Requirements
- R1: With `cs` high in IDLE, a low `di` at a clock edge leaves the controller in IDLE. The first high `di` is the start bit.
- R2: The two bits after the start bit form the register index. The first one received is index bit 0, and the index selects `wiper` slice index*8 +: 8.
- R3: The eight bits after the address are stored with the first received in bit 0 and the last in bit 7.
- R4: The addressed `wiper` slice keeps its old value through the edge that samples the last data bit. It takes the new value at the following edge. The other slices do not change.
- R5: In the cycle before the edge that samples data bit k (k = 0..7), `sdo` shows bit k of the register's old contents. At all other times `sdo` is 0.
- R6: `sdo_en` equals `cs`. A low `sdo_en` means the output is released (high impedance).
- R7: If `cs` is low at an edge while in DATA or COMMIT, the addressed register is reloaded from its `nv_vals` slice. If `cs` falls during IDLE or ADDR, no register changes.
- R8: `di` is ignored at the commit edge. The second edge after the last data bit can sample a new start bit.
- R9: While `rst_n` is low at a clock edge, every register loads its `nv_vals` slice and the controller returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Frame select, high during a transfer |
| di | input | 1 | Serial data in |
| nv_vals | input | 32 | Nonvolatile copies, register i at bits i*8 +: 8 |
| sdo | output | 1 | Serial data out (old contents) |
| sdo_en | output | 1 | Output driver enable; low means high impedance |
| wiper | output | 32 | Active settings, register i at bits i*8 +: 8 |

## Verification
The bench drives inputs on falling edges and samples outputs on the falling edge that follows, so every register update is observed half a cycle after the edge that made it. A read bit is due in the cycle before the edge that samples the matching data bit, so it is sampled before that input is driven. The new setting is due one edge after the last data bit, so the bench checks the old value after the D7 edge and the new one after the next edge. An abort takes effect at the first edge with `cs` low. The next start bit is driven for the second edge after D7.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_ADDR   = 2'd1,
        SW_DATA   = 2'd2,
        SW_COMMIT = 2'd3
    } sw_state_e;
endpackage

// File: rtl/sw_frame_fsm.sv
module sw_frame_fsm
    import sw_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8,
    localparam int CW = $clog2(((DW > AW) ? DW : AW) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          di,
    output sw_state_e     state,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] addr_next,
    output logic          load_sh,
    output logic          shift_en,
    output logic          commit,
    output logic          restore
);
    sw_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q, addr_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        if (!cs) begin
            state_d = SW_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SW_IDLE: begin
                    if (di) begin
                        state_d = SW_ADDR;
                        cnt_d   = '0;
                    end
                end
                SW_ADDR: begin
                    for (int i = 0; i < AW; i++) begin
                        if (cnt_q == CW'(i)) addr_d[i] = di;
                    end
                    if (cnt_q == CW'(AW - 1)) begin
                        state_d = SW_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SW_DATA: begin
                    if (cnt_q == CW'(DW - 1)) begin
                        state_d = SW_COMMIT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SW_COMMIT: state_d = SW_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
        end
    end

    // control outputs
    always_comb begin
        load_sh  = cs && (state_q == SW_ADDR) && (cnt_q == CW'(AW - 1));
        shift_en = cs && (state_q == SW_DATA);
        commit   = cs && (state_q == SW_COMMIT);
        restore  = !cs && ((state_q == SW_DATA) || (state_q == SW_COMMIT));
    end

    assign state     = state_q;
    assign cnt       = cnt_q;
    assign addr      = addr_q;
    assign addr_next = addr_d;
endmodule

// File: rtl/sw_wiper_bank.sv
module sw_wiper_bank #(
    parameter int AW = 2,
    parameter int DW = 8,
    localparam int NREG = 2 ** AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               restore,
    input  logic [AW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_idx,
    input  logic [NREG*DW-1:0] nv_vals,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] wiper
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= nv_vals[g*DW +: DW];
            end else if (commit && (wr_idx == AW'(g))) begin
                regs[g] <= wr_data;
            end else if (restore && (wr_idx == AW'(g))) begin
                regs[g] <= nv_vals[g*DW +: DW];
            end
        end
        assign wiper[g*DW +: DW] = regs[g];
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/sw_shifter.sv
module sw_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          din,
    input  logic [DW-1:0] par_in,
    output logic [DW-1:0] q,
    output logic          lsb
);
    logic [DW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= par_in;
        else if (shift) sh_q <= {din, sh_q[DW-1:1]};
    end

    assign q   = sh_q;
    assign lsb = sh_q[0];
endmodule

// File: rtl/sw_wiper_if.sv
module sw_wiper_if
    import sw_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8,
    localparam int NREG = 2 ** AW,
    localparam int CW = $clog2(((DW > AW) ? DW : AW) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               di,
    input  logic [NREG*DW-1:0] nv_vals,
    output logic               sdo,
    output logic               sdo_en,
    output logic [NREG*DW-1:0] wiper
);
    sw_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q, addr_next;
    logic          load_sh, shift_en, commit, restore;
    logic [DW-1:0] rd_data, sh_q;
    logic          sh_lsb;

    sw_frame_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di),
        .state(state_q), .cnt(cnt_q), .addr(addr_q), .addr_next(addr_next),
        .load_sh(load_sh), .shift_en(shift_en), .commit(commit), .restore(restore)
    );

    sw_wiper_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .restore(restore),
        .wr_idx(addr_q), .wr_data(sh_q), .rd_idx(addr_next),
        .nv_vals(nv_vals), .rd_data(rd_data), .wiper(wiper)
    );

    sw_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_sh), .shift(shift_en),
        .din(di), .par_in(rd_data), .q(sh_q), .lsb(sh_lsb)
    );

    assign sdo_en = cs;
    assign sdo    = cs && (state_q == SW_DATA) && sh_lsb;
endmodule

// File: rtl/sw_wiper_if_chk.sv
module sw_wiper_if_chk
    import sw_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8,
    localparam int NREG = 2 ** AW,
    localparam int CW = $clog2(((DW > AW) ? DW : AW) + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs,
    input logic               di,
    input sw_state_e          state,
    input logic [CW-1:0]      cnt,
    input logic [NREG*DW-1:0] wiper
);
    AST_IGNORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_IDLE && !di) |=> (state == SW_IDLE)); // R1

    AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && state == SW_ADDR && cnt == CW'(AW - 1)) |=> (state == SW_DATA)); // R2

    AST_D7_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && state == SW_DATA && cnt == CW'(DW - 1)) |=> (state == SW_COMMIT)); // R4

    AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == SW_IDLE)); // R7

    AST_IDLE_HOLDS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_IDLE && !cs) |=> $stable(wiper)); // R7

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_COMMIT) |=> (state == SW_IDLE)); // R8
endmodule

bind sw_wiper_if sw_wiper_if_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di),
    .state(state_q), .cnt(cnt_q), .wiper(wiper)
);

// File: tb/tb_sw_wiper_if.sv
module tb_sw_wiper_if;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cs, di;
    logic [31:0] nv_vals;
    logic        sdo, sdo_en;
    logic [31:0] wiper;

    logic [7:0] model [4];
    int checks = 0;
    int fails  = 0;

    sw_wiper_if dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .nv_vals(nv_vals),
        .sdo(sdo), .sdo_en(sdo_en), .wiper(wiper)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_vec();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_and_addr(input logic [1:0] a);
        cs = 1'b1; di = 1'b1; step();          // start bit (R1)
        for (int i = 0; i < 2; i++) begin       // A0 first (R2)
            di = a[i]; step();
        end
    endtask

    task automatic send_frame(input logic [1:0] a, input logic [7:0] d, input logic di_commit);
        logic [7:0] old_v;
        old_v = model[a];
        start_and_addr(a);
        for (int k = 0; k < 8; k++) begin
            chk(sdo == old_v[k], "R5 read bit", 32'(sdo), 32'(old_v[k]));
            di = d[k]; step();
        end
        chk(wiper == model_vec(), "R4 held after D7", wiper, model_vec());
        di = di_commit; step();
        model[a] = d;
        chk(wiper == model_vec(), "R3 R4 committed", wiper, model_vec());
        chk(sdo == 1'b0, "R5 quiet after frame", 32'(sdo), 32'd0);
        di = 1'b0;
    endtask

    task automatic abort_frame(input logic [1:0] a, input int nbits);
        logic [7:0] old_v;
        old_v = model[a];
        start_and_addr(a);
        for (int k = 0; k < nbits; k++) begin
            chk(sdo == old_v[k], "R5 read bit before abort", 32'(sdo), 32'(old_v[k]));
            di = ~old_v[k]; step();
        end
        cs = 1'b0; di = 1'b0; step();
        model[a] = nv_vals[a*8 +: 8];
        chk(wiper == model_vec(), "R7 abort restores", wiper, model_vec());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        nv_vals = 32'hC3_5A_81_2E;
        rst_n = 1'b0; cs = 1'b0; di = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = nv_vals[i*8 +: 8];

        // R9 reset state
        chk(wiper == nv_vals, "R9 reset loads nv", wiper, nv_vals);
        // R6 enable follows select
        chk(sdo_en == 1'b0, "R6 released when cs low", 32'(sdo_en), 32'd0);
        cs = 1'b1; #1;
        chk(sdo_en == 1'b1, "R6 driven when cs high", 32'(sdo_en), 32'd1);
        chk(sdo == 1'b0, "R5 quiet in idle", 32'(sdo), 32'd0);

        // R1 idle low bits ignored, then a frame
        @(negedge clk);
        di = 1'b0; repeat (4) step();
        chk(wiper == model_vec(), "R1 idle no change", wiper, model_vec());
        send_frame(2'd2, 8'hA5, 1'b0);          // R2 index 2
        send_frame(2'd1, 8'h3C, 1'b0);          // R2 index 1 (A0 high first)

        // R8 back-to-back, di high at commit edge ignored
        send_frame(2'd3, 8'h96, 1'b1);
        send_frame(2'd3, 8'h01, 1'b1);          // reads 96 back (R5)
        send_frame(2'd0, 8'hFF, 1'b0);

        // R7 aborts at several points
        abort_frame(2'd2, 3);
        abort_frame(2'd3, 8);                   // during COMMIT cycle
        abort_frame(2'd0, 0);
        // R7 early abort in ADDR: nothing changes
        cs = 1'b1; di = 1'b1; step();
        di = 1'b1; step();
        cs = 1'b0; di = 1'b0; step();
        chk(wiper == model_vec(), "R7 early abort no change", wiper, model_vec());
        chk(sdo_en == 1'b0, "R6 released after abort", 32'(sdo_en), 32'd0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [1:0] ra;
            logic [7:0] rd;
            ra = 2'($urandom_range(0, 3));
            rd = 8'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                abort_frame(ra, int'($urandom_range(0, 8)));
            end else begin
                send_frame(ra, rd, 1'($urandom_range(0, 1)));
                repeat ($urandom_range(0, 2)) step();
                if ($urandom_range(0, 1) == 1) begin
                    cs = 1'b0; step();
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule